// File: doc/BRIEF.md
# Pixel Repetition and Segment Splitter

This block sits after the pixel buffer of a display output pipe. It takes one active line at a time as a valid/ready pixel stream, marked at its first pixel by a start-of-line strobe. It sends the line out again as a sequence of horizontal segments for a panel link that carries one, two or four segments. The width of one segment is the active width divided by the segment count. Every real pixel can be sent several times in a row. Each segment can borrow overlap pixels from its neighbours, and a run of padding beats can close each segment.

A single line sequencer holds all four features. It walks a pixel index through each segment's window and takes a new input pixel only when that index first passes the count of pixels consumed so far. Pixels the sequencer has to send again come from a short history of recent input. The configuration is captured when a line starts. A setting that cannot be honoured raises an error flag, and that line passes through as a single plain segment.

Top module: `pxrep_seg_splitter`

## Requirements
- R1: While reset is held, out_valid and cfg_err are low. in_ready is low when in_valid is low.
- R2: Each real pixel appears on consecutive beats, rep+1 times in total, where rep is cfg_rep (0 to 15). A value of 0 means each pixel appears once.
- R3: cfg_segs selects the segment count: 0 gives 1, 1 gives 2 and 2 gives 4. With W = cfg_width, S = count and L = W/S, segment k holds input pixels k*L to (k+1)*L-1 as its core. Segments go out in order 0 to S-1, and out_seg carries k.
- R4: When S>1 and O = cfg_ovl, segment k adds the O pixels that come before its core if k>0, and the O pixels that come after its core if k<S-1. These are sent in index order, so the edge segments get overlap only on their inner side.
- R5: After its last real beat, each segment sends cfg_pad padding beats. A padding beat has out_pad=1 and carries the data of the segment's last real beat.
- R6: out_first is high only on the first beat of a segment. out_last is high only on the final beat of a segment, which is the last padding beat when cfg_pad>0.
- R7: in_ready is high during a line only in a cycle where a new input pixel can be taken. Gaps in in_valid stall the output, and no input pixel is lost or duplicated in the number of beats.
- R8: The configuration inputs are sampled once per line, in the cycle where in_valid and in_sol are first seen together while the block is idle. Changes made later in that line have no effect on it.
- R9: A setting is illegal if cfg_segs=3, if W is not divisible by S, or, with S>1, if O is 0, greater than 8 or greater than L. For an illegal setting, cfg_err is high for that line and the line goes out as one segment with no repetition, overlap or padding.
- R10: While idle, a pixel presented without in_sol is accepted and dropped. It never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high with in_valid |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_data | input | DATA_W | Input pixel |
| cfg_width | input | WIDTH_W | Active width W in input pixels |
| cfg_rep | input | REP_W | Extra copies of each real pixel |
| cfg_segs | input | 2 | Segment count code (0:1, 1:2, 2:4) |
| cfg_ovl | input | OVL_W | Overlap pixels per inner boundary |
| cfg_pad | input | PAD_W | Padding beats per segment |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output pixel |
| out_seg | output | 2 | Segment index of the beat |
| out_first | output | 1 | First beat of a segment |
| out_last | output | 1 | Final beat of a segment |
| out_pad | output | 1 | Beat is padding |
| cfg_err | output | 1 | Configuration of the current line was illegal |

## Verification
The properties assume an active width of at least one pixel. They also assume the configuration stays stable from the start-of-line pixel until the block samples it one cycle later. The bench only ever changes the configuration after the first pixel of a line has been taken. The padding and segment-order properties also assume that the output has no backpressure. In the stimulus, in_valid is driven with and without idle gaps, and one stray pixel is sent between lines. This covers both the stall path and the discard path.

// File: rtl/pxrep_pkg.sv
package pxrep_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PIX  = 2'd1,
      PH_PAD  = 2'd2
   } phase_t;

   localparam logic [1:0] SEGS_ONE  = 2'd0;
   localparam logic [1:0] SEGS_TWO  = 2'd1;
   localparam logic [1:0] SEGS_FOUR = 2'd2;

endpackage

// File: rtl/pxrep_cfg_check.sv
module pxrep_cfg_check #(
   parameter int WIDTH_W = 12,
   parameter int REP_W   = 4,
   parameter int OVL_W   = 4,
   parameter int OVL_MAX = 8,
   parameter int PAD_W   = 4
) (
   input  logic [WIDTH_W-1:0] width,
   input  logic [REP_W-1:0]   rep,
   input  logic [1:0]         segs,
   input  logic [OVL_W-1:0]   ovl,
   input  logic [PAD_W-1:0]   pad,
   output logic               bad,
   output logic [1:0]         eff_shift,
   output logic [REP_W-1:0]   eff_rep,
   output logic [OVL_W-1:0]   eff_ovl,
   output logic [PAD_W-1:0]   eff_pad,
   output logic [WIDTH_W-1:0] eff_len
);
   import pxrep_pkg::*;

   logic               div_ok;
   logic               ovl_ok;
   logic [WIDTH_W-1:0] len;

   always_comb begin
      unique case (segs)
         SEGS_ONE:  div_ok = 1'b1;
         SEGS_TWO:  div_ok = ~width[0];
         SEGS_FOUR: div_ok = (width[1:0] == 2'b00);
         default:   div_ok = 1'b0;
      endcase
   end

   assign len    = width >> segs;
   assign ovl_ok = (segs == SEGS_ONE) ||
                   ((ovl != '0) && (ovl <= OVL_W'(OVL_MAX)) && (WIDTH_W'(ovl) <= len));
   assign bad    = (segs == 2'd3) || !div_ok || !ovl_ok;

   assign eff_shift = bad ? 2'd0 : segs;
   assign eff_rep   = bad ? '0 : rep;
   assign eff_ovl   = (bad || segs == SEGS_ONE) ? '0 : ovl;
   assign eff_pad   = bad ? '0 : pad;
   assign eff_len   = bad ? width : len;

endmodule

// File: rtl/pxrep_seg_bounds.sv
module pxrep_seg_bounds #(
   parameter int WIDTH_W = 12,
   parameter int OVL_W   = 4
) (
   input  logic [1:0]         seg_idx,
   input  logic [1:0]         seg_last,
   input  logic [WIDTH_W-1:0] seg_len,
   input  logic [OVL_W-1:0]   ovl,
   output logic [WIDTH_W-1:0] first_idx,
   output logic [WIDTH_W-1:0] stop_idx
);
   logic [WIDTH_W-1:0] base;
   logic [WIDTH_W-1:0] ovl_ext;

   assign ovl_ext   = WIDTH_W'(ovl);
   assign base      = (seg_idx[1] ? (seg_len << 1) : '0) + (seg_idx[0] ? seg_len : '0);
   assign first_idx = base - ((seg_idx != 2'd0) ? ovl_ext : '0);
   assign stop_idx  = base + seg_len - WIDTH_W'(1) + ((seg_idx != seg_last) ? ovl_ext : '0);

endmodule

// File: rtl/pxrep_history.sv
module pxrep_history #(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] taps [DEPTH];

   always_ff @(posedge clk) begin
      if (push) begin
         taps[0] <= din;
         for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
      end
   end

   assign dout = taps[rd_idx];

endmodule

// File: rtl/pxrep_seg_splitter.sv
module pxrep_seg_splitter #(
   parameter int DATA_W  = 24,
   parameter int WIDTH_W = 12,
   parameter int REP_W   = 4,
   parameter int OVL_MAX = 8,
   parameter int OVL_W   = 4,
   parameter int PAD_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               in_sol,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [WIDTH_W-1:0] cfg_width,
   input  logic [REP_W-1:0]   cfg_rep,
   input  logic [1:0]         cfg_segs,
   input  logic [OVL_W-1:0]   cfg_ovl,
   input  logic [PAD_W-1:0]   cfg_pad,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   output logic [1:0]         out_seg,
   output logic               out_first,
   output logic               out_last,
   output logic               out_pad,
   output logic               cfg_err
);
   import pxrep_pkg::*;

   localparam int HIST_D = 2 * OVL_MAX;
   localparam int HIST_W = (HIST_D > 1) ? $clog2(HIST_D) : 1;

   if (DATA_W < 1 || REP_W < 1 || PAD_W < 1) begin : g_bad_width
      $error("pxrep_seg_splitter: field widths must be at least one bit");
   end
   if (OVL_MAX < 1 || OVL_MAX >= (1 << OVL_W)) begin : g_bad_ovl
      $error("pxrep_seg_splitter: OVL_MAX must be 1 or more and fit in OVL_W bits");
   end
   if (WIDTH_W < OVL_W + 2) begin : g_bad_line
      $error("pxrep_seg_splitter: WIDTH_W too narrow for four segments with overlap");
   end

   // Configuration captured at line start
   logic [1:0]         shift_q;
   logic [REP_W-1:0]   rep_q;
   logic [OVL_W-1:0]   ovl_q;
   logic [PAD_W-1:0]   pad_q;
   logic [WIDTH_W-1:0] len_q;
   logic               err_q;

   // Sequencer state
   phase_t             phase_q;
   logic [1:0]         seg_q;
   logic [WIDTH_W-1:0] idx_q;
   logic [WIDTH_W-1:0] cons_q;
   logic [REP_W-1:0]   rep_cnt_q;
   logic [PAD_W-1:0]   pad_cnt_q;

   // Checked configuration from the ports
   logic               chk_bad;
   logic [1:0]         chk_shift;
   logic [REP_W-1:0]   chk_rep;
   logic [OVL_W-1:0]   chk_ovl;
   logic [PAD_W-1:0]   chk_pad;
   logic [WIDTH_W-1:0] chk_len;

   pxrep_cfg_check #(
      .WIDTH_W(WIDTH_W), .REP_W(REP_W), .OVL_W(OVL_W), .OVL_MAX(OVL_MAX), .PAD_W(PAD_W)
   ) u_cfg (
      .width(cfg_width), .rep(cfg_rep), .segs(cfg_segs), .ovl(cfg_ovl), .pad(cfg_pad),
      .bad(chk_bad), .eff_shift(chk_shift), .eff_rep(chk_rep), .eff_ovl(chk_ovl),
      .eff_pad(chk_pad), .eff_len(chk_len)
   );

   logic [1:0]         seg_last;
   logic [WIDTH_W-1:0] cur_first;
   logic [WIDTH_W-1:0] cur_stop;
   logic [WIDTH_W-1:0] nxt_first;

   assign seg_last = {shift_q[1], |shift_q};

   pxrep_seg_bounds #(.WIDTH_W(WIDTH_W), .OVL_W(OVL_W)) u_bounds (
      .seg_idx(seg_q), .seg_last(seg_last), .seg_len(len_q), .ovl(ovl_q),
      .first_idx(cur_first), .stop_idx(cur_stop)
   );

   // Next segment opens 2*O before the current stop plus one
   assign nxt_first = cur_stop + WIDTH_W'(1) - (WIDTH_W'(ovl_q) << 1);

   logic               in_pix;
   logic               in_padph;
   logic               fetch;
   logic               fire;
   logic               rep_done;
   logic               pad_done;
   logic               seg_more;
   logic [DATA_W-1:0]  hist_dout;
   logic [DATA_W-1:0]  pix_val;
   logic [HIST_W-1:0]  hist_idx;

   assign in_pix   = (phase_q == PH_PIX);
   assign in_padph = (phase_q == PH_PAD);
   assign fetch    = in_pix && (idx_q == cons_q);
   assign in_ready = (phase_q == PH_IDLE) ? (in_valid && !in_sol) : fetch;
   assign fire     = in_pix ? (fetch ? in_valid : 1'b1) : in_padph;
   assign rep_done = (rep_cnt_q == rep_q);
   assign pad_done = (pad_cnt_q == pad_q - PAD_W'(1));
   assign seg_more = (seg_q != seg_last);
   assign hist_idx = HIST_W'(cons_q - idx_q - WIDTH_W'(1));

   pxrep_history #(.DATA_W(DATA_W), .DEPTH(HIST_D), .IDX_W(HIST_W)) u_hist (
      .clk(clk), .push(fetch && in_valid), .din(in_data), .rd_idx(hist_idx), .dout(hist_dout)
   );

   assign pix_val = fetch ? in_data : hist_dout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         shift_q   <= '0;
         rep_q     <= '0;
         ovl_q     <= '0;
         pad_q     <= '0;
         len_q     <= '0;
         err_q     <= 1'b0;
         seg_q     <= '0;
         idx_q     <= '0;
         cons_q    <= '0;
         rep_cnt_q <= '0;
         pad_cnt_q <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (in_valid && in_sol) begin
                  shift_q   <= chk_shift;
                  rep_q     <= chk_rep;
                  ovl_q     <= chk_ovl;
                  pad_q     <= chk_pad;
                  len_q     <= chk_len;
                  err_q     <= chk_bad;
                  seg_q     <= '0;
                  idx_q     <= '0;
                  cons_q    <= '0;
                  rep_cnt_q <= '0;
                  pad_cnt_q <= '0;
                  phase_q   <= PH_PIX;
               end
            end
            PH_PIX: begin
               if (fire) begin
                  if (fetch) cons_q <= cons_q + WIDTH_W'(1);
                  if (!rep_done) begin
                     rep_cnt_q <= rep_cnt_q + REP_W'(1);
                  end else begin
                     rep_cnt_q <= '0;
                     if (idx_q != cur_stop) begin
                        idx_q <= idx_q + WIDTH_W'(1);
                     end else if (pad_q != '0) begin
                        pad_cnt_q <= '0;
                        phase_q   <= PH_PAD;
                     end else if (seg_more) begin
                        seg_q <= seg_q + 2'd1;
                        idx_q <= nxt_first;
                     end else begin
                        phase_q <= PH_IDLE;
                     end
                  end
               end
            end
            PH_PAD: begin
               if (!pad_done) begin
                  pad_cnt_q <= pad_cnt_q + PAD_W'(1);
               end else if (seg_more) begin
                  seg_q   <= seg_q + 2'd1;
                  idx_q   <= nxt_first;
                  phase_q <= PH_PIX;
               end else begin
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // Registered output beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_seg   <= '0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_pad   <= 1'b0;
      end else begin
         out_valid <= fire;
         if (fire && in_pix) begin
            out_data  <= pix_val;
            out_seg   <= seg_q;
            out_first <= (idx_q == cur_first) && (rep_cnt_q == '0);
            out_last  <= (idx_q == cur_stop) && rep_done && (pad_q == '0);
            out_pad   <= 1'b0;
         end else if (fire) begin
            out_seg   <= seg_q;
            out_first <= 1'b0;
            out_last  <= pad_done;
            out_pad   <= 1'b1;
         end
      end
   end

   assign cfg_err = err_q;

endmodule

// File: rtl/pxrep_checker.sv
module pxrep_checker #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [1:0]        out_seg,
   input logic              out_first,
   input logic              out_last,
   input logic              out_pad,
   input logic              cfg_err
);

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_quiet_in_reset: assert (!out_valid && !cfg_err)
            else $error("R1: output active during reset");
      end
   end

   a_r5_pad_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_pad) |-> ($past(out_valid) && out_data == $past(out_data)))
      else $error("R5: padding beat changed data");

   a_r6_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_first && out_seg != 2'd0) |-> ($past(out_valid) && $past(out_last)))
      else $error("R6: segment opened without previous segment closing");

   a_r3_seg_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_first && out_seg != 2'd0) |-> (out_seg == $past(out_seg) + 2'd1))
      else $error("R3: segment index skipped");

   a_r9_err_single_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_err) |-> (out_seg == 2'd0 && !out_pad))
      else $error("R9: illegal setting not passed through");

endmodule

bind pxrep_seg_splitter pxrep_checker #(.DATA_W(DATA_W)) u_pxrep_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_data(out_data),
   .out_seg(out_seg), .out_first(out_first), .out_last(out_last),
   .out_pad(out_pad), .cfg_err(cfg_err)
);

// File: tb/test_pxrep_seg_splitter.sv
`timescale 1ns/1ps
module test_pxrep_seg_splitter;
   localparam int DATA_W = 24;
   localparam int WIDTH_W = 12;
   localparam int MAXB = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic in_sol = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic [WIDTH_W-1:0] cfg_width = '0;
   logic [3:0] cfg_rep = '0;
   logic [1:0] cfg_segs = '0;
   logic [3:0] cfg_ovl = '0;
   logic [3:0] cfg_pad = '0;
   logic out_valid, out_first, out_last, out_pad, cfg_err;
   logic [DATA_W-1:0] out_data;
   logic [1:0] out_seg;

   always #2 clk = ~clk;

   pxrep_seg_splitter i_pxrep_seg_splitter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
      .in_data(in_data), .cfg_width(cfg_width), .cfg_rep(cfg_rep), .cfg_segs(cfg_segs),
      .cfg_ovl(cfg_ovl), .cfg_pad(cfg_pad), .out_valid(out_valid), .out_data(out_data),
      .out_seg(out_seg), .out_first(out_first), .out_last(out_last), .out_pad(out_pad),
      .cfg_err(cfg_err)
   );

   int checks = 0;
   int errors = 0;
   int line_no = 0;
   bit finished = 1'b0;

   int exp_n, got_n;
   bit exp_err;
   logic [DATA_W-1:0] exp_data [MAXB];
   logic [1:0] exp_seg [MAXB];
   logic [2:0] exp_flags [MAXB];
   logic [DATA_W-1:0] got_data [MAXB];
   logic [1:0] got_seg [MAXB];
   logic [2:0] got_flags [MAXB];
   logic got_err [MAXB];

   always @(negedge clk) begin
      if (out_valid && got_n < MAXB) begin
         got_data[got_n]  <= out_data;
         got_seg[got_n]   <= out_seg;
         got_flags[got_n] <= {out_first, out_last, out_pad};
         got_err[got_n]   <= cfg_err;
         got_n <= got_n + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s line %0d actual=%0h expected=%0h", tag, what, line_no, act, expv);
      end
   endtask

   function automatic logic [DATA_W-1:0] pv(input int ln, input int i);
      return DATA_W'((ln << 12) + i + 1);
   endfunction

   task automatic push_exp(input logic [DATA_W-1:0] d, input int k, input bit f, input bit l, input bit p);
      if (exp_n < MAXB) begin
         exp_data[exp_n] = d;
         exp_seg[exp_n] = 2'(k);
         exp_flags[exp_n] = {f, l, p};
      end
      exp_n++;
   endtask

   task automatic gen_expected(input int w, input int r, input int code, input int o, input int p);
      int s, len, st, sp;
      bit bad;
      s = 1 << code;
      bad = (code == 3) || (w % s != 0);
      if (!bad && s > 1) bad = (o < 1) || (o > 8) || (o > w / s);
      if (bad) begin s = 1; r = 0; o = 0; p = 0; end
      if (s == 1) o = 0;
      exp_err = bad;
      len = w / s;
      exp_n = 0;
      for (int k = 0; k < s; k++) begin
         st = k * len - ((k > 0) ? o : 0);
         sp = (k + 1) * len - 1 + ((k < s - 1) ? o : 0);
         for (int j = st; j <= sp; j++)
            for (int q = 0; q <= r; q++)
               push_exp(pv(line_no, j), k, (j == st && q == 0), (j == sp && q == r && p == 0), 1'b0);
         for (int q = 0; q < p; q++)
            push_exp(pv(line_no, sp), k, 1'b0, (q == p - 1), 1'b1);
      end
   endtask

   task automatic send_pixel(input logic [DATA_W-1:0] d, input bit sol);
      @(negedge clk);
      in_valid = 1'b1; in_sol = sol; in_data = d;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
   endtask

   task automatic run_case(input string tag, input int w, input int r, input int code,
                           input int o, input int p, input bit gap, input int midrep);
      int n;
      line_no++;
      gen_expected(w, r, code, o, p);
      @(negedge clk);
      cfg_width = WIDTH_W'(w); cfg_rep = 4'(r); cfg_segs = 2'(code);
      cfg_ovl = 4'(o); cfg_pad = 4'(p);
      got_n = 0;
      for (int i = 0; i < w; i++) begin
         send_pixel(pv(line_no, i), (i == 0));
         if (i == 1 && midrep >= 0) begin
            // R8: configuration edits after capture
            cfg_rep = 4'(midrep); cfg_pad = 4'(p + 1); cfg_ovl = 4'(o + 1);
         end
         if (gap && (i % 3 == 2)) begin
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0;
      for (int c = 0; c < 3000 && got_n < exp_n; c++) @(posedge clk);
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(got_n == exp_n, "R7", "beat count", got_n, exp_n);
      n = (got_n < exp_n) ? got_n : exp_n;
      if (n > MAXB) n = MAXB;
      for (int i = 0; i < n; i++) begin
         check({got_seg[i], got_data[i]} == {exp_seg[i], exp_data[i]}, tag, "seg/data",
               {got_seg[i], got_data[i]}, {exp_seg[i], exp_data[i]});
         check(got_flags[i][0] == exp_flags[i][0], "R5", "pad flag", got_flags[i][0], exp_flags[i][0]);
         check(got_flags[i][2:1] == exp_flags[i][2:1], "R6", "first/last", got_flags[i][2:1], exp_flags[i][2:1]);
      end
      if (n > 0) check(got_err[0] == exp_err, "R9", "error flag", got_err[0], exp_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      got_n = 0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
      check(!in_ready, "R1", "in_ready in reset", in_ready, 0);
      check(!cfg_err, "R1", "cfg_err in reset", cfg_err, 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // Sweep of legal settings on an eight-pixel line
      for (int code = 0; code < 3; code++)
         for (int o = 1; o <= 2; o++)
            for (int r = 0; r <= 2; r += 2)
               for (int p = 0; p <= 1; p++) begin
                  if (code == 0 && o == 2) continue;
                  run_case((p > 0) ? "R5" : (code > 0) ? "R4" : (r > 0) ? "R2" : "R3",
                           8, r, code, o, p, bit'(line_no % 2), -1);
               end

      // Boundary settings
      run_case("R4", 16, 0, 1, 8, 2, 1'b0, -1);   // maximum overlap equal to segment width
      run_case("R3", 12, 1, 2, 3, 0, 1'b1, -1);   // four segments, overlap equal to width
      run_case("R2", 6, 15, 0, 1, 0, 1'b0, -1);   // largest repetition
      run_case("R7", 10, 0, 1, 2, 0, 1'b1, -1);   // input gaps

      // R8: edits during the line have no effect
      run_case("R8", 8, 1, 1, 1, 0, 1'b0, 3);

      // R10: a stray pixel while idle is taken and dropped
      @(negedge clk);
      in_valid = 1'b1; in_sol = 1'b0; in_data = 24'hABCDEF;
      #1;
      check(in_ready, "R10", "stray pixel accepted", in_ready, 1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(!out_valid, "R10", "no beat from stray pixel", out_valid, 0);
      run_case("R10", 8, 0, 1, 1, 1, 1'b0, -1);

      // R9: illegal settings pass through as one plain segment
      run_case("R9", 10, 2, 2, 1, 1, 1'b0, -1);   // width not divisible
      run_case("R9", 8, 1, 3, 1, 0, 1'b0, -1);    // reserved segment code
      run_case("R9", 8, 1, 1, 0, 1, 1'b1, -1);    // zero overlap
      run_case("R9", 8, 0, 1, 9, 0, 1'b0, -1);    // overlap above eight
      run_case("R9", 8, 0, 2, 3, 0, 1'b0, -1);    // overlap wider than segment
      run_case("R3", 8, 0, 2, 2, 0, 1'b0, -1);    // legal line after errors clears flag

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule